// File: doc/BRIEF.md
# Latch-Width Command Sequencer

This block produces the serial command traffic that brings up a chain of LED driver chips with scrambled PWM. Those chips share one clock line, one latch line and a set of colour data lines. They tell commands apart only by how many clock pulses arrive while the latch line is high. When the block gets a start request it plays one fixed configuration sequence. First comes a pre-activation command, then an enable-all-outputs command, then a vertical sync. After that it does five rounds, each made of an idle gap, a pre-activation and one 16-bit configuration register write. In each write the latch window length selects the target register.

Each half of a serial clock period lasts one enable tick, so the serial rate is set by how often `tick` pulses. The five register values come in on `cfg_words`. The register written with the 4-clock window carries the panel's scan line count, and the block puts that count in automatically. The host watches `busy` and waits for the one-cycle `done` pulse before it starts greyscale traffic.

Top module: `latch_cmd_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after reset until a start is accepted, `ser_clk`, `ser_lat`, `ser_rgb`, `busy` and `done` are all 0.
- R2: A pre-activation command is 14 clock pulses with the latch high across all 14, and every `ser_rgb` line is 0 at each of those rising edges. The first output cycle after a start shows the latch already high.
- R3: An enable-all-outputs command is 12 clock pulses with the latch high across all 12.
- R4: A vertical sync is one clock pulse with the latch low, followed by 3 pulses with the latch high.
- R5: One run emits exactly 13 latched commands in this order: pre-activation, enable, vertical sync, then five pairs of pre-activation and register write for r = 0 to 4.
- R6: Register write r shifts 16 bits out MSB first, one bit per rising clock edge. All `ser_rgb` lines carry the same bit. The latch is high for the final 2·r+2 pulses only, giving windows of 2, 4, 6, 8 and 10. Register r is taken from `cfg_words[16r+15:16r]`.
- R7: In register 1 (the 4-clock window), bits 15:8 are sent as (`scan_lines` − 1) modulo 256, and bits 7:0 are sent unchanged.
- R8: Latch-low spacing is measured in tick periods P. Before each of the five pre-activations that lead a register write, the latch stays low for (G+1)·P cycles, where G is `gap_len`, or 1 when `gap_len` is 0. The clock stays low through that gap. Before an enable command the spacing is P. Before a vertical sync it is 3·P. Before write r it is (1 + 2·(16 − (2r+2)))·P.
- R9: A `start` pulse while `busy` is high has no effect: the run in progress still emits exactly the R5 sequence.
- R10: `busy` is high from the first cycle after a start is captured. `done` is high for exactly one cycle, P cycles after the last latch falls. `busy` falls in the same cycle that `done` rises.
- R11: While `tick` is held low, `ser_clk`, `ser_lat` and `ser_rgb` hold their values (after one cycle of output register delay), and the run resumes correctly afterwards.
- R12: `ser_lat` changes only in cycles where `ser_clk` is low, so it is stable at every rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Enable tick; each serial clock phase lasts one tick |
| start | input | 1 | Request to begin the configuration sequence |
| cfg_words | input | NREG*WORD_W | Register values, register r at bits [WORD_W*r +: WORD_W] |
| scan_lines | input | SCAN_W | Number of scan lines of the panel |
| gap_len | input | GAP_W | Idle ticks before each register pre-activation (0 acts as 1) |
| ser_clk | output | 1 | Serial shift clock to the driver chain |
| ser_lat | output | 1 | Latch line; its high window encodes the command |
| ser_rgb | output | LANES | Colour data lines, all carrying the same bit |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence has finished |

## Verification
The sequencer state moves only on ticks, and every output is registered, so each pin lags its state by exactly one clock. That lag cancels out of every interval the bench measures. Latch-low spacing is counted in whole cycles and must equal a multiple of the tick period P: one, three, gap plus one, or the write lead-in. `done` is due P cycles after the final latch fall, and `busy` is due on the second sample after the cycle that drove `start`. Commands are rebuilt from rising edges of `ser_clk` seen at falling edges of `clk`, so the expected counts and words do not depend on when any particular edge lands.

// File: rtl/lcs_pkg.sv
// Package: shared constants and the per-step descriptor of the sequencer.
// Assumes command pulse counts stay below 64.
package lcs_pkg;

    localparam int PREACT_PULSES = 14;
    localparam int ENABLE_PULSES = 12;
    localparam int VSYNC_PULSES  = 4;
    localparam int VSYNC_LATCHED = 3;
    localparam int SCAN_REG      = 1;

    typedef struct packed {
        logic       is_gap;
        logic       is_write;
        logic [5:0] n_pulse;
        logic [5:0] n_latch;
        logic [3:0] reg_idx;
    } step_t;

endpackage

// File: rtl/lcs_step_decode.sv
// Step decoder: maps a step index to what that step emits.
// Steps 0..2 are pre-activation, enable and vsync. Every later group of
// three is gap, pre-activation, register write. Assumes NREG <= 16.
module lcs_step_decode
    import lcs_pkg::*;
#(
    parameter int NREG   = 5,
    parameter int WORD_W = 16,
    parameter int STEP_W = 5
) (
    input  logic [STEP_W-1:0] step,
    output step_t             st
);

    // Decode one step into its pulse count, latch window and register index.
    always_comb begin
        int s;
        int rel;
        int r;
        st  = '0;
        s   = int'(step);
        rel = s - 3;
        r   = rel / 3;
        if (s == 0) begin
            st.n_pulse = 6'(PREACT_PULSES);
            st.n_latch = 6'(PREACT_PULSES);
        end else if (s == 1) begin
            st.n_pulse = 6'(ENABLE_PULSES);
            st.n_latch = 6'(ENABLE_PULSES);
        end else if (s == 2) begin
            st.n_pulse = 6'(VSYNC_PULSES);
            st.n_latch = 6'(VSYNC_LATCHED);
        end else if (r < NREG) begin
            case (rel % 3)
                0: st.is_gap = 1'b1;
                1: begin
                    st.n_pulse = 6'(PREACT_PULSES);
                    st.n_latch = 6'(PREACT_PULSES);
                end
                default: begin
                    st.is_write = 1'b1;
                    st.n_pulse  = 6'(WORD_W);
                    st.n_latch  = 6'(2 * r + 2);
                    st.reg_idx  = 4'(r);
                end
            endcase
        end
    end

endmodule

// File: rtl/lcs_word_sel.sv
// Word selector: picks the register value to shift out. In the scan
// register the upper SCAN_W bits are replaced by scan_lines - 1.
// Assumes WORD_W > SCAN_W.
module lcs_word_sel
    import lcs_pkg::*;
#(
    parameter int NREG   = 5,
    parameter int WORD_W = 16,
    parameter int SCAN_W = 8
) (
    input  logic [NREG*WORD_W-1:0] cfg_words,
    input  logic [SCAN_W-1:0]      scan_lines,
    input  logic [3:0]             reg_idx,
    output logic [WORD_W-1:0]      word
);

    localparam int LOW_W = WORD_W - SCAN_W;
    localparam logic [WORD_W-1:0] HI_MASK = {{SCAN_W{1'b1}}, {LOW_W{1'b0}}};

    logic [SCAN_W-1:0] scan_m1;
    logic [WORD_W-1:0] adj [NREG];

    assign scan_m1 = scan_lines - SCAN_W'(1);

    // Build the word each register will carry.
    for (genvar g = 0; g < NREG; g++) begin : g_adj
        if (g == SCAN_REG) begin : g_scan
            assign adj[g] = (cfg_words[g*WORD_W +: WORD_W] & ~HI_MASK)
                          | {scan_m1, {LOW_W{1'b0}}};
        end else begin : g_plain
            assign adj[g] = cfg_words[g*WORD_W +: WORD_W];
        end
    end

    // Select the word of the register being written.
    always_comb begin
        word = '0;
        for (int g = 0; g < NREG; g++) begin
            if (reg_idx == 4'(g)) word = adj[g];
        end
    end

endmodule

// File: rtl/lcs_pulse_gen.sv
// Pulse generator: turns the phase counter of one command into the clock,
// latch and data levels. An even count is a low phase and an odd count a
// high phase. Count 2N is the trailing low phase, in which the latch drops.
module lcs_pulse_gen #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic [CNT_W-1:0]  cnt,
    input  logic [5:0]        n_pulse,
    input  logic [5:0]        n_latch,
    input  logic              is_write,
    input  logic [WORD_W-1:0] word,
    output logic              clk_n,
    output logic              lat_n,
    output logic              bit_n,
    output logic              last
);

    logic [CNT_W-1:0]  span;
    logic [CNT_W-1:0]  k;
    logic [CNT_W-1:0]  lat_from;
    logic [WORD_W-1:0] sh;
    logic              in_cmd;

    // Derive the levels for the current phase of the command.
    always_comb begin
        span     = CNT_W'({n_pulse, 1'b0});
        k        = cnt >> 1;
        lat_from = CNT_W'(n_pulse) - CNT_W'(n_latch);
        in_cmd   = cnt < span;
        sh       = word << k;
        clk_n    = in_cmd & cnt[0];
        lat_n    = in_cmd & (k >= lat_from);
        bit_n    = in_cmd & is_write & sh[WORD_W-1];
        last     = (cnt == span);
    end

endmodule

// File: rtl/latch_cmd_seq.sv
// Top: plays the driver configuration sequence on the serial command
// interface. State moves only on tick. All outputs are registered and so
// follow the state by one clock. Assumes gap_len of 0 means one tick.
module latch_cmd_seq
    import lcs_pkg::*;
#(
    parameter int LANES  = 6,
    parameter int NREG   = 5,
    parameter int WORD_W = 16,
    parameter int SCAN_W = 8,
    parameter int GAP_W  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   start,
    input  logic [NREG*WORD_W-1:0] cfg_words,
    input  logic [SCAN_W-1:0]      scan_lines,
    input  logic [GAP_W-1:0]       gap_len,
    output logic                   ser_clk,
    output logic                   ser_lat,
    output logic [LANES-1:0]       ser_rgb,
    output logic                   busy,
    output logic                   done
);

    localparam int NSTEPS = 3 + 3 * NREG;
    localparam int STEP_W = $clog2(NSTEPS);
    localparam int CNT_W  = (GAP_W > 7) ? GAP_W : 7;

    logic              run_q;
    logic              fin_q;
    logic [STEP_W-1:0] step_q;
    logic [CNT_W-1:0]  cnt_q;
    step_t             st;
    logic [WORD_W-1:0] word;
    logic              p_clk;
    logic              p_lat;
    logic              p_bit;
    logic              p_last;
    logic [CNT_W-1:0]  gap_top;
    logic              step_end;

    lcs_step_decode #(.NREG(NREG), .WORD_W(WORD_W), .STEP_W(STEP_W)) u_dec (
        .step (step_q),
        .st   (st)
    );

    lcs_word_sel #(.NREG(NREG), .WORD_W(WORD_W), .SCAN_W(SCAN_W)) u_word (
        .cfg_words  (cfg_words),
        .scan_lines (scan_lines),
        .reg_idx    (st.reg_idx),
        .word       (word)
    );

    lcs_pulse_gen #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_pulse (
        .cnt      (cnt_q),
        .n_pulse  (st.n_pulse),
        .n_latch  (st.n_latch),
        .is_write (st.is_write),
        .word     (word),
        .clk_n    (p_clk),
        .lat_n    (p_lat),
        .bit_n    (p_bit),
        .last     (p_last)
    );

    // Decide whether the current step ends on this tick.
    always_comb begin
        gap_top  = (gap_len == '0) ? '0 : CNT_W'(gap_len - 1'b1);
        step_end = st.is_gap ? (cnt_q >= gap_top) : p_last;
    end

    // Sequencer state: accept start when idle, advance phase and step on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            fin_q  <= 1'b0;
            step_q <= '0;
            cnt_q  <= '0;
        end else begin
            fin_q <= 1'b0;
            if (!run_q) begin
                if (start && !busy) begin
                    run_q  <= 1'b1;
                    step_q <= '0;
                    cnt_q  <= '0;
                end
            end else if (tick) begin
                if (step_end) begin
                    cnt_q <= '0;
                    if (step_q == STEP_W'(NSTEPS - 1)) begin
                        run_q <= 1'b0;
                        fin_q <= 1'b1;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // Output register: one clean flop per pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_clk <= 1'b0;
            ser_lat <= 1'b0;
            ser_rgb <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else begin
            ser_clk <= run_q & p_clk;
            ser_lat <= run_q & p_lat;
            ser_rgb <= {LANES{run_q & p_bit}};
            busy    <= run_q;
            done    <= fin_q;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ser_clk && !ser_lat));

    p_step_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (int'(step_q) < NSTEPS));

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && step_q != '0) |=> (step_q != '0));

    p_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_tick_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !tick) |=> ($stable(step_q) && $stable(cnt_q)));

    p_lat_change_clk_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_lat) |-> !ser_clk);

    p_lat_steady_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_lat));

endmodule

// File: tb/tb_latch_cmd_seq.sv
`timescale 1ns/1ps
module tb_latch_cmd_seq;

    localparam int LANES  = 6;
    localparam int NREG   = 5;
    localparam int WORD_W = 16;
    localparam int GAP_W  = 8;

    // Columns: tick period, gap_len, scan_lines, register words 0..4
    localparam int VEC [4][8] = '{
        '{1, 3, 32, 16'hA5C3, 16'h1234, 16'hF00F, 16'h8001, 16'h7E5A},
        '{2, 1, 16, 16'hFFFF, 16'h00FF, 16'h0000, 16'h5555, 16'hAAAA},
        '{3, 6,  1, 16'h0F1E, 16'hFFFF, 16'h3C3C, 16'h0001, 16'h8000},
        '{1, 0,  0, 16'h1111, 16'h2222, 16'h4444, 16'h8888, 16'hC001}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic start = 1'b0;
    logic [NREG*WORD_W-1:0] cfg_words = '0;
    logic [7:0] scan_lines = '0;
    logic [GAP_W-1:0] gap_len = '0;
    logic ser_clk, ser_lat, busy, done;
    logic [LANES-1:0] ser_rgb;

    int checks = 0;
    int errors = 0;
    int per = 1;
    bit hold = 1'b0;
    int tcnt = 0;

    // monitor state
    int cyc = 0;
    int ev_n, rise_n, pul, lat, lowc;
    int ev_pul [64];
    int ev_lat [64];
    int ev_word [64];
    int ev_rgb [64];
    int low_len [64];
    logic [15:0] shw;
    bit anyr;
    logic pclk = 1'b0, plat = 1'b0, pbusy = 1'b0;
    int lane_bad, r12_bad, done_n, done_cyc, fall_cyc;
    logic busy_at_done, busy_before_done;

    always #2 clk = ~clk;

    latch_cmd_seq #(.LANES(LANES), .NREG(NREG), .WORD_W(WORD_W), .SCAN_W(8), .GAP_W(GAP_W)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .cfg_words(cfg_words), .scan_lines(scan_lines), .gap_len(gap_len),
        .ser_clk(ser_clk), .ser_lat(ser_lat), .ser_rgb(ser_rgb),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        ev_n = 0; rise_n = 0; pul = 0; lat = 0; lowc = 0; shw = '0; anyr = 0;
        lane_bad = 0; r12_bad = 0; done_n = 0; done_cyc = 0; fall_cyc = 0;
    endtask

    // tick generator: one tick every per cycles unless held
    initial begin
        forever begin
            @(negedge clk);
            if (hold) begin
                tick = 1'b0;
            end else if (tcnt >= per - 1) begin
                tcnt = 0;
                tick = 1'b1;
            end else begin
                tcnt++;
                tick = 1'b0;
            end
        end
    end

    // monitor: rebuild commands from the serial pins
    initial begin
        clear_mon();
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (ser_rgb != '0 && ser_rgb != '1) lane_bad++;
                if (ser_lat != plat && ser_clk) r12_bad++;
                if (ser_clk && !pclk) begin
                    pul++;
                    if (ser_lat) lat++;
                    shw  = {shw[14:0], ser_rgb[0]};
                    anyr = anyr | (|ser_rgb);
                end
                if (!ser_lat) begin
                    lowc++;
                end else if (!plat) begin
                    if (rise_n < 64) low_len[rise_n] = lowc;
                    rise_n++;
                    lowc = 0;
                end
                if (!ser_lat && plat) begin
                    if (ev_n < 64) begin
                        ev_pul[ev_n]  = pul;
                        ev_lat[ev_n]  = lat;
                        ev_word[ev_n] = int'(shw);
                        ev_rgb[ev_n]  = int'(anyr);
                    end
                    ev_n++;
                    pul = 0; lat = 0; shw = '0; anyr = 0;
                    fall_cyc = cyc;
                end
                if (done) begin
                    done_n++;
                    done_cyc = cyc;
                    busy_at_done = busy;
                    busy_before_done = pbusy;
                end
            end
            pclk = ser_clk;
            plat = ser_lat;
            pbusy = busy;
        end
    end

    task automatic do_run(input int p, input int g, input int scan,
                          input int w0, input int w1, input int w2, input int w3, input int w4,
                          input bit stall, input bit poke, input bit chk_low);
        int t;
        int ge;
        int snap;
        int bad;
        int w [5];
        w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3; w[4] = w4;
        ge = (g == 0) ? 1 : g;
        per = p;
        gap_len = GAP_W'(g);
        scan_lines = 8'(scan);
        cfg_words = {16'(w4), 16'(w3), 16'(w2), 16'(w1), 16'(w0)};
        @(negedge clk);
        clear_mon();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
        chk(ser_lat == 1'b1, "R2 latch high at first output", int'(ser_lat), 1);
        if (stall) begin
            repeat (100) @(negedge clk);
            hold = 1'b1;
            repeat (2) @(negedge clk);
            snap = int'({ser_clk, ser_lat, ser_rgb});
            bad = 0;
            repeat (40) begin
                @(negedge clk);
                if (int'({ser_clk, ser_lat, ser_rgb}) != snap) bad++;
            end
            chk(bad == 0, "R11 outputs hold without tick", bad, 0);
            hold = 1'b0;
        end
        if (poke) begin
            repeat (200) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
        chk(t < 20000, "R10 done reached", t, 0);
        chk(ev_n == 13, "R5 command count", ev_n, 13);
        for (int e = 0; e < 13; e++) begin
            int rel;
            int r;
            int wexp;
            if (e == 0) begin
                chk(ev_pul[e] == 14 && ev_lat[e] == 14, "R2 preact pulses", ev_pul[e]*100 + ev_lat[e], 1414);
                chk(ev_rgb[e] == 0, "R2 preact data low", ev_rgb[e], 0);
            end else if (e == 1) begin
                chk(ev_pul[e] == 12 && ev_lat[e] == 12, "R3 enable pulses", ev_pul[e]*100 + ev_lat[e], 1212);
            end else if (e == 2) begin
                chk(ev_pul[e] == 4 && ev_lat[e] == 3, "R4 vsync pulses", ev_pul[e]*100 + ev_lat[e], 403);
            end else begin
                rel = e - 3;
                r = rel / 2;
                if (rel % 2 == 0) begin
                    chk(ev_pul[e] == 14 && ev_lat[e] == 14, "R5 preact before write", ev_pul[e]*100 + ev_lat[e], 1414);
                    chk(ev_rgb[e] == 0, "R2 preact data low", ev_rgb[e], 0);
                end else begin
                    chk(ev_pul[e] == 16 && ev_lat[e] == 2*r+2, "R6 write window", ev_pul[e]*100 + ev_lat[e], 1600 + 2*r + 2);
                    if (r == 1) begin
                        wexp = (((scan - 1) & 255) << 8) | (w[r] & 255);
                        chk(ev_word[e] == wexp, "R7 scan register word", ev_word[e], wexp);
                    end else begin
                        wexp = w[r] & 16'hFFFF;
                        chk(ev_word[e] == wexp, "R6 register word", ev_word[e], wexp);
                    end
                end
            end
        end
        if (chk_low) begin
            for (int i = 1; i < 13; i++) begin
                int rel;
                int r;
                int lexp;
                if (i == 1) lexp = p;
                else if (i == 2) lexp = 3 * p;
                else begin
                    rel = i - 3;
                    r = rel / 2;
                    if (rel % 2 == 0) lexp = (ge + 1) * p;
                    else lexp = (1 + 2 * (16 - (2*r + 2))) * p;
                end
                chk(low_len[i] == lexp, "R8 latch-low spacing", low_len[i], lexp);
            end
        end
        chk(done_n == 1, "R10 done pulse count", done_n, 1);
        chk(busy_at_done == 1'b0 && busy_before_done == 1'b1, "R10 busy falls with done",
            int'({busy_before_done, busy_at_done}), 2);
        chk(done_cyc - fall_cyc == p, "R10 done delay after last latch", done_cyc - fall_cyc, p);
        chk(lane_bad == 0, "R6 lanes identical", lane_bad, 0);
        chk(r12_bad == 0, "R12 latch moves only with clock low", r12_bad, 0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk({ser_clk, ser_lat, ser_rgb, busy, done} == '0, "R1 outputs zero in reset",
            int'({ser_clk, ser_lat, ser_rgb, busy, done}), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk({ser_clk, ser_lat, ser_rgb, busy, done} == '0, "R1 idle without start",
            int'({ser_clk, ser_lat, ser_rgb, busy, done}), 0);

        for (int v = 0; v < 4; v++) begin
            do_run(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4],
                   VEC[v][5], VEC[v][6], VEC[v][7], 1'b0, 1'b0, 1'b1);
        end

        // R9: start pulse in mid-run must not restart the sequence
        do_run(1, 2, 24, 16'h0F0F, 16'h3344, 16'h6006, 16'hB00B, 16'h1FE0, 1'b0, 1'b1, 1'b1);

        // R11: tick held low mid-run, then resumed
        do_run(1, 4, 8, 16'h9669, 16'hABCD, 16'h0102, 16'hFEDC, 16'h7001, 1'b1, 1'b0, 1'b0);

        repeat (5) @(negedge clk);
        chk({ser_clk, ser_lat, busy, done} == '0, "R1 quiet after runs",
            int'({ser_clk, ser_lat, busy, done}), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule